// File: doc/BRIEF.md
# Clock Generator Control Register Target

This block is the serial control port of a clock generator. It acts only as a target on a two-wire SMBus. It holds a small bank of configuration bytes and turns their contents into a few registered control outputs: a spread-spectrum select bit, two frequency-margining select fields and a sixteen-bit output-enable vector. The bus lines are oversampled in the system clock domain. The target drives SDA in open-drain form and never stretches SCL. The system clock must run at least sixteen times faster than SCL, so that 400 kHz fast mode is supported.

Transfers use the indexed block protocol. For a write, the host sends the write address, a starting index, a nonzero byte count and then that many data bytes. For a read, the host sends the write address and the starting index, then a repeated Start and the read address. The target answers with a byte count, followed by the bytes from the starting index upward, until the host NAKs.

An active-low power-down input returns every register to its power-up value and forces all enables off. A two-bit mode field in byte 0 selects who gates the outputs: the pin as a whole, a software kill, or the individual enable bits.

Top module: `clkgen_ctl_slave`

## Requirements
- R1: The target ACKs address byte 0xD2 (7-bit address 0x69, write). It ACKs 0xD3 (read) only after an index has been accepted since the last Stop. Every other address byte is NAKed and the rest of the transfer is ignored.
- R2: In a block write, data bytes go to consecutive indexes, starting at the index byte. Exactly the number of bytes given by the count is ACKed and stored. Any further data byte is NAKed and not stored.
- R3: A count byte of zero is NAKed, and no data byte of that transfer is stored.
- R4: An index byte of 7 or more is NAKed.
- R5: In a block read, the first byte the target sends is 7 minus the index. It then sends the bytes from the index upward, most significant bit first, for as long as the host ACKs. It releases SDA after the host's NAK.
- R6: Values after reset: byte0 0x35, byte1 0xF0, byte2 0x80, byte3 0x06.
- R7: Write-protected bits are ACKed but keep their value: byte2 bits 4..0, byte3 bit 0, and bytes 4, 5 and 6. Bytes 4 and 5 and the protected bits read as 0. Byte 6 reads 0x03.
- R8: While pd_n is low, bytes 0..3 hold their reset values and out_en is all zero.
- R9: The outputs are gated by byte0 bit6 and bit5. With bit6=0, all bits of out_en equal pd_n. With bit6=1 and bit5=0, out_en is zero. With bit6=1 and bit5=1, out_en equals the vector built from the enable bits. In that vector, bit 0 is byte0 bit0, bits 8..1 are byte1 bits 7..0, and bits 15..9 are byte3 bits 7..1.
- R10: spread_sel is byte0 bit7. fsel_a is byte0 bits 4..1. fsel_b is byte2 bits 7..5.
- R11: A Stop ends any transfer and discards the accepted index, so a read address sent after that Stop is NAKed until a new index is sent.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low synchronous system reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| pd_n | input | 1 | Active-low power-down: restores defaults and disables outputs |
| spread_sel | output | 1 | Spread-spectrum select |
| fsel_a | output | 4 | Margining select for the first output group |
| fsel_b | output | 3 | Frequency select for the selectable output |
| out_en | output | 16 | Per-output enable after mode gating |

## Verification
A corrupted index, count or phase inside the target first shows up on SDA. It appears as a wrong ACK or NAK within the ninth SCL clock of the byte where it happens, or as a wrong count or data byte on the next read-back. A register that takes a wrong value, or a gating mode that is decoded wrongly, shows on spread_sel, fsel_a, fsel_b or out_en within two system clocks. Those ports are compared with a behavioural model on every clock while the bus is quiet. The power-down and abort cases are probed through later transfers, so that state left behind by a bad reset or a missed Stop becomes visible.

// File: rtl/clkgen_ctl_pkg.sv
package clkgen_ctl_pkg;

    localparam int REG_BYTES = 7;
    localparam int RW_BYTES  = 4;
    localparam int IDX_W     = $clog2(REG_BYTES + 1);
    localparam int NUM_OE    = 16;
    localparam logic [6:0] DEV_ADDR = 7'h69;
    localparam logic [7:0] ID_BYTE  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR, PH_OFF, PH_CNT, PH_DATA
    } phase_e;

    function automatic logic [7:0] wr_mask(input int unsigned idx);
        case (idx)
            0, 1:    return 8'hFF;
            2:       return 8'hE0;
            3:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h35;
            1:       return 8'hF0;
            2:       return 8'h80;
            3:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkgen_ctl_linesync.sv
module clkgen_ctl_linesync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-1:0], raw[g]};
        end
        assign lvl[g]  = sh_q[STAGES-1];
        assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/clkgen_ctl_regs.sv
module clkgen_ctl_regs
    import clkgen_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic              spread_sel,
    output logic [3:0]        fsel_a,
    output logic [2:0]        fsel_b,
    output logic [NUM_OE-1:0] out_en
);
    typedef struct packed {
        logic [RW_BYTES-1:0][7:0] b;
        logic [NUM_OE-1:0]        en;
    } regs_t;

    regs_t q, d;
    logic [NUM_OE-1:0] vec;

    always_comb begin
        d   = q;
        vec = {q.b[3][7:1], q.b[1], q.b[0][0]};
        for (int i = 0; i < RW_BYTES; i++) begin
            if (!pd_n)
                d.b[i] = reg_default(i);
            else if (wr_en && (int'(wr_idx) == i))
                d.b[i] = (q.b[i] & ~wr_mask(i)) | (wr_data & wr_mask(i));
        end
        if (!pd_n)              d.en = '0;
        else if (!q.b[0][6])    d.en = '1;
        else if (!q.b[0][5])    d.en = '0;
        else                    d.en = vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RW_BYTES; i++) q.b[i] <= reg_default(i);
            q.en <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (int'(rd_idx) < RW_BYTES)            rd_data = q.b[rd_idx[1:0]];
        else if (int'(rd_idx) == REG_BYTES - 1) rd_data = ID_BYTE;
        else                                    rd_data = 8'h00;
    end

    assign spread_sel = q.b[0][7];
    assign fsel_a     = q.b[0][4:1];
    assign fsel_b     = q.b[2][7:5];
    assign out_en     = q.en;

    p_pd_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (q.b[0] == 8'h35 && q.b[1] == 8'hF0 && q.b[2] == 8'h80 && q.b[3] == 8'h06));
    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (out_en == '0));
    p_hw_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !q.b[0][6]) |=> (&out_en));
    p_sw_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && q.b[0][6] && !q.b[0][5]) |=> (out_en == '0));
endmodule

// File: rtl/clkgen_ctl_slave.sv
module clkgen_ctl_slave
    import clkgen_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    input  logic              pd_n,
    output logic              spread_sel,
    output logic [3:0]        fsel_a,
    output logic [2:0]        fsel_b,
    output logic [NUM_OE-1:0] out_en
);
    typedef struct packed {
        bus_st_e          st;
        phase_e           ph;
        logic [3:0]       bits;
        logic [7:0]       sh;
        logic [IDX_W-1:0] idx;
        logic [7:0]       remain;
        logic             off_ok;
        logic             rd;
        logic             ack;
        logic             pull;
    } fsm_t;

    fsm_t q, d;
    logic [1:0] lvl, rise, fall;
    logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_c, stop_c;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0] rd_data;

    clkgen_ctl_linesync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign scl_lvl  = lvl[0];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign sda_lvl  = lvl[1];
    assign start_c  = scl_lvl & fall[1];
    assign stop_c   = scl_lvl & rise[1];

    function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] v);
        return (int'(v) < REG_BYTES) ? v + 1'b1 : v;
    endfunction

    always_comb begin
        d      = q;
        wr_en  = 1'b0;
        wr_idx = q.idx;
        if (stop_c) begin
            d.st = ST_IDLE; d.pull = 1'b0; d.off_ok = 1'b0;
        end else if (start_c) begin
            d.st = ST_RX; d.ph = PH_ADDR; d.bits = '0; d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bits != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_lvl};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.ack = 1'b0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh == {DEV_ADDR, 1'b0}) begin
                                    d.ack = 1'b1; d.rd = 1'b0; d.off_ok = 1'b0; d.ph = PH_OFF;
                                end else if (q.sh == {DEV_ADDR, 1'b1} && q.off_ok) begin
                                    d.ack = 1'b1; d.rd = 1'b1;
                                    d.sh  = 8'(REG_BYTES) - 8'(q.idx);
                                end
                            end
                            PH_OFF: if (q.sh < 8'(REG_BYTES)) begin
                                d.ack = 1'b1; d.idx = q.sh[IDX_W-1:0];
                                d.off_ok = 1'b1; d.ph = PH_CNT;
                            end
                            PH_CNT: if (q.sh != 8'h00) begin
                                d.ack = 1'b1; d.remain = q.sh; d.ph = PH_DATA;
                            end
                            default: if (q.remain != 8'h00) begin
                                d.ack    = 1'b1;
                                d.remain = q.remain - 1'b1;
                                wr_en    = (int'(q.idx) < REG_BYTES);
                                d.idx    = idx_inc(q.idx);
                            end
                        endcase
                        d.pull = d.ack;
                        d.st   = ST_ACK;
                        d.bits = '0;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    d.bits = '0;
                    if (!q.ack)    begin d.st = ST_IGNORE; d.pull = 1'b0; end
                    else if (q.rd) begin d.st = ST_TX; d.pull = ~q.sh[7]; end
                    else           begin d.st = ST_RX; d.pull = 1'b0; end
                end
                ST_TX: if (scl_fall) begin
                    if (q.bits == 4'd7) begin
                        d.st = ST_MACK; d.pull = 1'b0;
                    end else begin
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.pull = ~q.sh[6];
                        d.bits = q.bits + 1'b1;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) d.ack = ~sda_lvl;
                    else if (scl_fall) begin
                        if (q.ack) begin
                            d.st = ST_TX; d.bits = '0; d.sh = rd_data;
                            d.pull = ~rd_data[7]; d.idx = idx_inc(q.idx);
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, bits: '0, sh: '0, idx: '0,
                   remain: '0, off_ok: 1'b0, rd: 1'b0, ack: 1'b0, pull: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull = q.pull;

    clkgen_ctl_regs regs_i (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(q.sh),
        .rd_idx(q.idx), .rd_data(rd_data),
        .spread_sel(spread_sel), .fsel_a(fsel_a), .fsel_b(fsel_b), .out_en(out_en)
    );

    p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !start_c && !stop_c) |-> $stable(sda_pull));
    p_tx_needs_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX) |-> q.off_ok);
    p_ignore_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE || q.st == ST_IDLE) |=> (!sda_pull || start_c || stop_c || q.st != ST_IDLE));
endmodule

// File: tb/clkgen_ctl_slave_tb_top.sv
module clkgen_ctl_slave_tb_top;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, pd_n = 1'b1;
    logic sda_pull, spread_sel;
    logic [3:0] fsel_a;
    logic [2:0] fsel_b;
    logic [15:0] out_en;
    wire sda_bus = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    clkgen_ctl_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
        .pd_n(pd_n), .spread_sel(spread_sel), .fsel_a(fsel_a), .fsel_b(fsel_b), .out_en(out_en)
    );

    int checks = 0, errors = 0, hold_viol = 0;
    logic busy = 1'b1, pd_m = 1'b1;
    logic [7:0] mdl [7];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int i);
        case (i) 0: return 8'h35; 1: return 8'hF0; 2: return 8'h80; 3: return 8'h06;
            6: return 8'h03; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] msk(input int i);
        case (i) 0, 1: return 8'hFF; 2: return 8'hE0; 3: return 8'hFE; default: return 8'h00; endcase
    endfunction
    task automatic mdl_reset();
        for (int i = 0; i < 7; i++) mdl[i] = dflt(i);
    endtask
    function automatic logic [15:0] exp_en();
        logic [15:0] v;
        v[0] = mdl[0][0];
        for (int i = 0; i < 8; i++) v[1+i] = mdl[1][i];
        for (int i = 1; i < 8; i++) v[8+i] = mdl[3][i];
        if (!pd_m) return 16'h0;
        if (!mdl[0][6]) return 16'hFFFF;
        if (!mdl[0][5]) return 16'h0;
        return v;
    endfunction

    logic scl_prev = 1'b1, pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            chk(out_en == exp_en(), "R9 out_en", out_en, exp_en());
            chk({spread_sel, fsel_a, fsel_b} == {mdl[0][7], mdl[0][4:1], mdl[2][7:5]},
                "R10 selects", {spread_sel, fsel_a, fsel_b}, {mdl[0][7], mdl[0][4:1], mdl[2][7:5]});
        end
        if (rst_n && scl_m && scl_prev && sda_pull != pull_prev) hold_viol++;
        scl_prev  = scl_m;
        pull_prev = sda_pull;
    end

    task automatic waitq(input int n); repeat (n) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; waitq(Q); scl_m = 1; waitq(Q); sda_m = 0; waitq(Q); scl_m = 0; waitq(Q); endtask
    task automatic bus_stop(); sda_m = 0; waitq(Q); scl_m = 1; waitq(Q); sda_m = 1; waitq(Q); endtask
    task automatic put_bit(input logic b); sda_m = b; waitq(Q); scl_m = 1; waitq(2*Q); scl_m = 0; waitq(Q); endtask
    task automatic get_bit(output logic b); sda_m = 1; waitq(Q); scl_m = 1; waitq(Q); b = sda_bus; waitq(Q); scl_m = 0; waitq(Q); endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b); ack = !b;
    endtask
    task automatic recv_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(!mack);
    endtask
    task automatic settle(); waitq(6); busy = 0; endtask

    task automatic wr_block(input int off, input int cnt, input logic [7:0] data [], input string req);
        logic a; int idx;
        busy = 1;
        bus_start();
        send_byte(8'hD2, a); chk(a, "R1 write addr ack", a, 1);
        send_byte(8'(off), a); chk(a == (off < 7), "R4 index ack", a, off < 7);
        if (a) begin
            send_byte(8'(cnt), a); chk(a == (cnt != 0), "R3 count ack", a, cnt != 0);
            idx = off;
            for (int k = 0; a && k < data.size(); k++) begin
                send_byte(data[k], a);
                chk(a == (k < cnt), {req, " R2 data ack"}, a, k < cnt);
                if (a) begin
                    if (idx < 7) mdl[idx] = (mdl[idx] & ~msk(idx)) | (data[k] & msk(idx));
                    if (idx < 7) idx++;
                end
            end
        end
        bus_stop();
        settle();
    endtask

    task automatic rd_block(input int off, input int n, input string req);
        logic a; logic [7:0] v;
        busy = 1;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'(off), a);
        bus_start();
        send_byte(8'hD3, a); chk(a, "R1 read addr ack", a, 1);
        recv_byte(v, 1'b1); chk(v == 8'(7 - off), "R5 count", v, 7 - off);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            chk(v == mdl[off+k], {req, " R5 data"}, v, mdl[off+k]);
        end
        bus_stop();
        chk(sda_pull == 1'b0, "R5 released", sda_pull, 0);
        settle();
    endtask

    initial begin
        #3_000_000;
        errors++; checks++;
        $display("FAIL watchdog R1 actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a;
        mdl_reset();
        repeat (5) @(negedge clk);
        rst_n = 1;
        waitq(4);
        chk({spread_sel, fsel_a, fsel_b} == {1'b0, 4'b1010, 3'b100}, "R6 reset selects",
            {spread_sel, fsel_a, fsel_b}, {1'b0, 4'b1010, 3'b100});
        chk(out_en == 16'hFFFF, "R6 reset out_en", out_en, 16'hFFFF);
        busy = 0;

        rd_block(0, 7, "R6 R7 defaults");
        wr_block(1, 2, '{8'h0F, 8'hFF}, "R2 R7");
        rd_block(1, 2, "R7 masked");
        wr_block(0, 1, '{8'h61}, "R9 sw mode");
        waitq(20);
        wr_block(3, 1, '{8'hAB}, "R9 vector");
        waitq(20);
        wr_block(0, 1, '{8'h41}, "R9 kill");
        waitq(20);
        wr_block(0, 1, '{8'hB5}, "R10 spread");
        wr_block(2, 1, '{8'h40}, "R10 fsel_b");
        wr_block(6, 1, '{8'hFF}, "R7 id");
        rd_block(5, 2, "R7 id read");
        wr_block(1, 0, '{8'h00}, "R3 zero");
        rd_block(1, 1, "R3 unchanged");
        wr_block(9, 1, '{8'h00}, "R4 bad index");
        wr_block(2, 1, '{8'hE0, 8'h12}, "R2 overrun");
        rd_block(2, 2, "R2 overrun check");

        busy = 1; bus_start();
        send_byte(8'hA0, a); chk(!a, "R1 foreign addr nak", a, 0);
        bus_stop(); settle();

        busy = 1; bus_start();
        send_byte(8'hD2, a); send_byte(8'h03, a); bus_stop();
        bus_start(); send_byte(8'hD3, a); chk(!a, "R11 read after stop nak", a, 0);
        bus_stop(); settle();

        wr_block(0, 1, '{8'h00}, "R9 pin mode");
        busy = 1; pd_n = 0; waitq(4); pd_m = 0;
        mdl_reset(); busy = 0; waitq(20);
        chk(out_en == 16'h0, "R8 pd off", out_en, 0);
        busy = 1; pd_n = 1; waitq(4); pd_m = 1; busy = 0; waitq(10);
        rd_block(0, 4, "R8 defaults restored");

        chk(hold_viol == 0, "R12 sda hold", hold_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule